// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Two-Bit Comparison Code

This block is a purely combinational arithmetic-logic unit joined to its operation decoder. It takes two operands and a three-bit operation code from the main instruction control. It also takes the six-bit function field of the current instruction. It returns a result word and a two-bit comparison code. The operation code either names the operation outright, or it carries a reserved value that hands the choice to the function field, which is how register-type instructions select their operation.

The unit supports addition, subtraction, AND, OR, NOR and a signed set-less-than. A comparison is made by asking the unit to subtract. While it subtracts, the comparison code reports whether the first operand equals the second and whether it is greater under signed two's-complement rules. The greater-than flag is taken from the difference's sign corrected by the overflow, not from the sign alone. For every other operation the comparison code reads zero.

Top module: `alu_cmp_unit`

## Requirements
- R1: With opCode 3'b000 the result equals opA plus opB, modulo 2^32.
- R2: With opCode 3'b001 the result equals opA minus opB, modulo 2^32.
- R3: opCode 3'b010 gives the bitwise AND, 3'b011 the bitwise OR and 3'b100 the bitwise NOR of opA and opB.
- R4: opCode 3'b101 puts 1 in result bit 0 when opA is less than opB as signed numbers, otherwise 0; all other result bits are 0.
- R5: opCode 3'b111 selects the operation from funcField: 6'h20 add, 6'h22 subtract, 6'h24 AND, 6'h25 OR, 6'h27 NOR, 6'h2A set-less-than.
- R6: Under opCode 3'b111 any other funcField value performs addition, and opCode 3'b110 also performs addition.
- R7: When opCode is not 3'b111, funcField has no effect on result or cmpCode.
- R8: During subtraction cmpCode bit 0 is 1 exactly when opA equals opB.
- R9: During subtraction cmpCode bit 1 is 1 exactly when opA is greater than opB as signed numbers, including operand pairs whose difference overflows.
- R10: When the operation is not subtraction (set-less-than included), cmpCode is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opCode | input | 3 | Operation from main control; 3'b111 defers to funcField |
| funcField | input | 6 | Function field of a register-type instruction |
| result | output | 32 | Operation result |
| cmpCode | output | 2 | Bit 1: opA greater than opB (signed); bit 0: equal; valid in subtraction only |

## Verification
The checker assumes every input is at a known level whenever it samples, since its immediate assertions compare settled output values against the ports and would be meaningless on unknown operands or codes. The bench drives all four inputs together on the falling clock edge from a single task call, so a complete, defined input set is present before any comparison is made. The bench also picks operand pairs at the signed extremes so that the overflow-corrected greater-than path is reached, rather than only pairs whose difference keeps its sign.

// File: rtl/alu_cmp_pkg.sv
package alu_cmp_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_AND  = 3'b010,
    OP_OR   = 3'b011,
    OP_NOR  = 3'b100,
    OP_SLT  = 3'b101,
    OP_RSVD = 3'b110,
    OP_FUNC = 3'b111
  } aluOp_e;

  typedef enum logic [1:0] {
    RES_ARITH = 2'd0,
    RES_LOGIC = 2'd1,
    RES_LESS  = 2'd2
  } resSel_e;

  typedef enum logic [1:0] {
    LOG_AND = 2'd0,
    LOG_OR  = 2'd1,
    LOG_NOR = 2'd2
  } logSel_e;

  typedef struct packed {
    logic    subtract;
    logic    cmpEnable;
    resSel_e resSel;
    logSel_e logSel;
  } aluStrobe_t;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_NOR = 6'h27;
  localparam logic [5:0] FN_SLT = 6'h2A;

endpackage

// File: rtl/alu_cmp_ctrl.sv
module alu_cmp_ctrl
  import alu_cmp_pkg::*;
(
  input  logic [2:0] opCode,
  input  logic [5:0] funcField,
  output aluStrobe_t strobe
);

  aluOp_e fieldOp;
  aluOp_e effOp;

  always_comb begin
    case (funcField)
      FN_SUB:  fieldOp = OP_SUB;
      FN_AND:  fieldOp = OP_AND;
      FN_OR:   fieldOp = OP_OR;
      FN_NOR:  fieldOp = OP_NOR;
      FN_SLT:  fieldOp = OP_SLT;
      default: fieldOp = OP_ADD;
    endcase
  end

  always_comb begin
    if (aluOp_e'(opCode) == OP_FUNC) effOp = fieldOp;
    else                             effOp = aluOp_e'(opCode);
  end

  always_comb begin
    strobe.subtract  = 1'b0;
    strobe.cmpEnable = 1'b0;
    strobe.resSel    = RES_ARITH;
    strobe.logSel    = LOG_AND;
    case (effOp)
      OP_SUB: begin
        strobe.subtract  = 1'b1;
        strobe.cmpEnable = 1'b1;
      end
      OP_AND: strobe.resSel = RES_LOGIC;
      OP_OR: begin
        strobe.resSel = RES_LOGIC;
        strobe.logSel = LOG_OR;
      end
      OP_NOR: begin
        strobe.resSel = RES_LOGIC;
        strobe.logSel = LOG_NOR;
      end
      OP_SLT: begin
        strobe.subtract = 1'b1;
        strobe.resSel   = RES_LESS;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_cmp_datapath.sv
module alu_cmp_datapath
  import alu_cmp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobe_t       strobe,
  output logic [WIDTH-1:0] result,
  output logic [1:0]       cmpCode
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bEff;
  logic [WIDTH:0]   sumWide;
  logic [WIDTH-1:0] sum;
  logic             overflow;
  logic             lessSigned;
  logic             isZero;
  logic [WIDTH-1:0] logicOut;

  assign bEff    = strobe.subtract ? ~opB : opB;
  assign sumWide = {1'b0, opA} + {1'b0, bEff} + {{WIDTH{1'b0}}, strobe.subtract};
  assign sum     = sumWide[WIDTH-1:0];

  assign overflow   = (opA[MSB] == bEff[MSB]) && (sum[MSB] != opA[MSB]);
  assign lessSigned = sum[MSB] ^ overflow;
  assign isZero     = (sum == '0);

  always_comb begin
    case (strobe.logSel)
      LOG_OR:  logicOut = opA | opB;
      LOG_NOR: logicOut = ~(opA | opB);
      default: logicOut = opA & opB;
    endcase
  end

  always_comb begin
    case (strobe.resSel)
      RES_LOGIC: result = logicOut;
      RES_LESS:  result = {{(WIDTH-1){1'b0}}, lessSigned};
      default:   result = sum;
    endcase
  end

  assign cmpCode = strobe.cmpEnable ? {~lessSigned & ~isZero, isZero} : 2'b00;

endmodule

// File: rtl/alu_cmp_unit.sv
module alu_cmp_unit
  import alu_cmp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       opCode,
  input  logic [5:0]       funcField,
  output logic [WIDTH-1:0] result,
  output logic [1:0]       cmpCode
);

  aluStrobe_t strobe;

  alu_cmp_ctrl u_ctrl (
    .opCode    (opCode),
    .funcField (funcField),
    .strobe    (strobe)
  );

  alu_cmp_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobe  (strobe),
    .result  (result),
    .cmpCode (cmpCode)
  );

endmodule

// File: rtl/alu_cmp_checker.sv
module alu_cmp_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       opCode,
  input logic [5:0]       funcField,
  input logic [WIDTH-1:0] result,
  input logic [1:0]       cmpCode
);

  logic portSub;
  logic portSlt;
  assign portSub = (opCode == 3'b001) || (opCode == 3'b111 && funcField == 6'h22);
  assign portSlt = (opCode == 3'b101) || (opCode == 3'b111 && funcField == 6'h2A);

  always_comb begin
    // R10
    cmp_idle_chk: assert (portSub || cmpCode == 2'b00);
    // R8
    eq_match_chk: assert (!(portSub && cmpCode[0]) || (opA == opB && result == '0));
    // R9
    gt_signed_chk: assert (!(portSub && cmpCode[1]) || ($signed(opA) > $signed(opB)));
    // R8
    cmp_exclusive_chk: assert (cmpCode != 2'b11);
    // R4
    slt_upper_chk: assert (!portSlt || result[WIDTH-1:1] == '0);
  end

endmodule

bind alu_cmp_unit alu_cmp_checker #(.WIDTH(WIDTH)) u_chk (
  .opA       (opA),
  .opB       (opB),
  .opCode    (opCode),
  .funcField (funcField),
  .result    (result),
  .cmpCode   (cmpCode)
);

// File: tb/test_alu_cmp_unit.sv
module test_alu_cmp_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [2:0]  opCode = '0;
  logic [5:0]  funcField = '0;
  logic [31:0] result;
  logic [1:0]  cmpCode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_cmp_unit i_alu_cmp_unit (
    .opA(opA), .opB(opB), .opCode(opCode), .funcField(funcField),
    .result(result), .cmpCode(cmpCode)
  );

  task automatic apply(input logic [2:0] op, input logic [5:0] fn,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] expRes, input logic [1:0] expCmp,
                       input string req);
    @(negedge clk);
    opCode = op; funcField = fn; opA = a; opB = b;
    #1;
    checks++;
    if (result !== expRes || cmpCode !== expCmp) begin
      errors++;
      $display("FAIL %s: result=%h cmp=%b expected result=%h cmp=%b",
               req, result, cmpCode, expRes, expCmp);
    end
  endtask

  task automatic test_idle();
    apply(3'b000, 6'h00, 32'h0, 32'h0, 32'h0, 2'b00, "R1 idle");
  endtask

  task automatic test_add();
    apply(3'b000, 6'h00, 32'd2, 32'd3, 32'd5, 2'b00, "R1");
    apply(3'b000, 6'h00, 32'hFFFF_FFFF, 32'd1, 32'h0, 2'b00, "R1 wrap R10");
  endtask

  task automatic test_sub();
    apply(3'b001, 6'h00, 32'd5, 32'd5, 32'h0, 2'b01, "R2 R8 equal");
    apply(3'b001, 6'h00, 32'd3, 32'd7, 32'hFFFF_FFFC, 2'b00, "R2 R9 less");
    apply(3'b001, 6'h00, 32'd7, 32'd3, 32'd4, 2'b10, "R2 R9 greater");
    apply(3'b001, 6'h00, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 2'b10, "R9 overflow gt");
    apply(3'b001, 6'h00, 32'h8000_0000, 32'd1, 32'h7FFF_FFFF, 2'b00, "R9 overflow lt");
    apply(3'b001, 6'h00, 32'hFFFF_FFFF, 32'd1, 32'hFFFF_FFFE, 2'b00, "R9 neg vs pos");
  endtask

  task automatic test_logic();
    apply(3'b010, 6'h00, 32'hF0F0_1234, 32'h0FF0_FF00, 32'h00F0_1200, 2'b00, "R3 AND");
    apply(3'b011, 6'h00, 32'hF0F0_1234, 32'h0FF0_FF00, 32'hFFF0_FF34, 2'b00, "R3 OR");
    apply(3'b100, 6'h00, 32'hF0F0_1234, 32'h0FF0_FF00, 32'h000F_00CB, 2'b00, "R3 NOR R10");
  endtask

  task automatic test_slt();
    apply(3'b101, 6'h00, 32'hFFFF_FFFF, 32'd1, 32'd1, 2'b00, "R4 neg<pos R10");
    apply(3'b101, 6'h00, 32'd1, 32'hFFFF_FFFF, 32'd0, 2'b00, "R4 pos>neg");
    apply(3'b101, 6'h00, 32'h8000_0000, 32'h7FFF_FFFF, 32'd1, 2'b00, "R4 overflow");
    apply(3'b101, 6'h00, 32'd9, 32'd9, 32'd0, 2'b00, "R4 equal");
  endtask

  task automatic test_funct();
    apply(3'b111, 6'h20, 32'd2, 32'd3, 32'd5, 2'b00, "R5 add");
    apply(3'b111, 6'h22, 32'd5, 32'd5, 32'd0, 2'b01, "R5 sub");
    apply(3'b111, 6'h22, 32'd8, 32'd1, 32'd7, 2'b10, "R5 sub gt");
    apply(3'b111, 6'h24, 32'hF0F0_1234, 32'h0FF0_FF00, 32'h00F0_1200, 2'b00, "R5 and");
    apply(3'b111, 6'h25, 32'hF0F0_1234, 32'h0FF0_FF00, 32'hFFF0_FF34, 2'b00, "R5 or");
    apply(3'b111, 6'h27, 32'hF0F0_1234, 32'h0FF0_FF00, 32'h000F_00CB, 2'b00, "R5 nor");
    apply(3'b111, 6'h2A, 32'hFFFF_FFFE, 32'd0, 32'd1, 2'b00, "R5 slt");
  endtask

  task automatic test_default();
    apply(3'b111, 6'h21, 32'd10, 32'd20, 32'd30, 2'b00, "R6 funct 21");
    apply(3'b111, 6'h00, 32'd10, 32'd20, 32'd30, 2'b00, "R6 funct 00");
    apply(3'b110, 6'h22, 32'd10, 32'd20, 32'd30, 2'b00, "R6 op 110");
  endtask

  task automatic test_ignore();
    apply(3'b010, 6'h22, 32'hFF00_FF00, 32'h0F0F_0F0F, 32'h0F00_0F00, 2'b00, "R7 and");
    apply(3'b000, 6'h22, 32'd4, 32'd4, 32'd8, 2'b00, "R7 add");
    apply(3'b001, 6'h20, 32'd4, 32'd4, 32'd0, 2'b01, "R7 sub");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    test_idle();
    test_add();
    test_sub();
    test_logic();
    test_slt();
    test_funct();
    test_default();
    test_ignore();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule